// File: doc/BRIEF.md
# Bus Stall and Timeout Watchdog

This block is a passive observer for a pipelined memory-mapped bus. It samples the read and write strobes, the slave's stall line (waitrequest), the read-response strobe (readdatavalid) and the burst length, and it never drives any of them. Four independent limits are enforced: how long the stall line may stay high without a break, how long the oldest outstanding read may wait for its response, how long a burst write may take from its first beat to its last, and how many reads may be in flight at once. A response strobe that arrives when nothing is outstanding is reported as a separate fault.

Every fault has a one-cycle pulse output and a sticky flag that stays set until a synchronous reset. An optional input register stage can be switched in by parameter, which delays every result by one cycle. For slaves that have no response strobe, a fixed-latency variant synthesises the response a set number of cycles after each accepted read.

Top module: `mm_stall_watchdog`

## Requirements
- R1: A read or write is accepted only in a sampled cycle where its strobe is high and the stall line is low; a read held under stall starts no response timer and adds nothing to the outstanding count.
- R2: When the stall line has been sampled high for STALL_LIMIT (default 1024) consecutive cycles, the stall fault (bit 0) pulses once; a low cycle restarts the count, and a longer stretch raises no second pulse.
- R3: With reads outstanding, if no response arrives in the RD_LIMIT (default 100) cycles following the acceptance of the oldest read (or following the previous response), the read-timeout fault (bit 1) pulses once; a response in the last of those cycles raises nothing.
- R4: The outstanding-read count rises by one per accepted read and falls by one per response; a read accepted with no response in the same cycle while the count already equals MAX_PENDING (default 1) raises the overflow fault (bit 3). The count saturates at 2^ceil(log2(MAX_PENDING+2))-1.
- R5: A response with no read outstanding and no read accepted in the same cycle raises the orphan-response fault (bit 4) and leaves the count unchanged; a response in the same cycle as an acceptance at count zero is matched to it.
- R6: An accepted write outside a burst opens a burst when its burst length is above one (length 0 counts as 1); each later accepted write is one beat, and if the last beat is not accepted within WR_LIMIT (default 100) cycles after the first, the write-timeout fault (bit 2) pulses once.
- R7: Each fault pulse is high for one cycle, one clock edge after the sampled cycle that caused it; the sticky flag of the same bit rises with it and stays high until reset.
- R8: With REG_IN set, every pulse and flag appears exactly one cycle later than without it, for the same bus activity.
- R9: A synchronous active-high reset clears all pulses, flags, counters and burst state.
- R10: With HAS_RDV cleared, the response strobe input is ignored and each accepted read is answered FIXED_LAT cycles after acceptance, so neither the read-timeout nor the orphan fault can occur; stall and write checks behave as with the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_read | input | 1 | Observed read strobe |
| bus_write | input | 1 | Observed write strobe |
| bus_waitreq | input | 1 | Observed slave stall line |
| bus_rdvalid | input | 1 | Observed read-response strobe |
| bus_burstcount | input | BURST_W | Observed burst length, read on the first beat of a write |
| err_pulse | output | 5 | One-cycle fault pulses: 0 stall, 1 read timeout, 2 write timeout, 3 overflow, 4 orphan response |
| err_flag | output | 5 | Sticky fault flags, same bit order |

## Verification
Every fault is decided from the bus values sampled at one clock edge and appears on the pulse and flag outputs right after that edge, so the bench drives each cycle's bus values at the falling edge, advances its own reference model with those same values, and compares all outputs one nanosecond after the next rising edge. The instance with the input register is compared against the reference delayed by exactly one cycle, and the fixed-latency instance is compared on the stall and write bits while its read faults must stay clear. Limit boundaries are hit directly: a response in the last allowed cycle, a stall of exactly the limit length and beyond, and a burst stalled past its window.

// File: rtl/mmwd_pkg.sv
package mmwd_pkg;

    localparam int NUM_ERR  = 5;
    localparam int ERR_STALL = 0;
    localparam int ERR_RDTO  = 1;
    localparam int ERR_WRTO  = 2;
    localparam int ERR_OVF   = 3;
    localparam int ERR_ORPH  = 4;

    typedef logic [NUM_ERR-1:0] err_vec_t;

    typedef struct packed {
        logic rd;
        logic wr;
        logic wq;
        logic rdv;
    } bus_smp_t;

    typedef enum logic {
        WB_IDLE  = 1'b0,
        WB_BURST = 1'b1
    } wburst_state_t;

    function automatic logic accepted(input logic req, input logic stall);
        return req && !stall;
    endfunction

endpackage

// File: rtl/mmwd_in_stage.sv
module mmwd_in_stage
    import mmwd_pkg::*;
#(
    parameter int BURST_W = 4,
    parameter bit REG_IN  = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd,
    input  logic               wr,
    input  logic               wq,
    input  logic               rdv,
    input  logic [BURST_W-1:0] burst,
    output bus_smp_t           smp,
    output logic [BURST_W-1:0] smp_burst
);

    bus_smp_t raw;
    assign raw = '{rd: rd, wr: wr, wq: wq, rdv: rdv};

    generate
        if (REG_IN) begin : g_reg
            bus_smp_t           smp_q;
            logic [BURST_W-1:0] burst_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    smp_q   <= '0;
                    burst_q <= '0;
                end else begin
                    smp_q   <= raw;
                    burst_q <= burst;
                end
            end
            assign smp       = smp_q;
            assign smp_burst = burst_q;
        end else begin : g_pass
            assign smp       = raw;
            assign smp_burst = burst;
        end
    endgenerate

endmodule

// File: rtl/mmwd_age_timer.sv
module mmwd_age_timer #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic fire
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
    localparam logic [CW-1:0] TOP  = CW'(LIMIT);

    logic [CW-1:0] age;

    always_ff @(posedge clk) begin
        if (rst) begin
            age <= '0;
        end else if (!run) begin
            age <= '0;
        end else if (age != TOP) begin
            age <= age + 1'b1;
        end
    end

    assign fire = run && (age == LAST);

    // R7
    fire_once_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire);

endmodule

// File: rtl/mmwd_read_tracker.sv
module mmwd_read_tracker
    import mmwd_pkg::*;
#(
    parameter int MAX_PENDING = 1,
    parameter bit HAS_RDV     = 1'b1,
    parameter int FIXED_LAT   = 0,
    parameter int RD_LIMIT    = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic rd,
    input  logic wq,
    input  logic rdv,
    output logic ovf,
    output logic orphan,
    output logic rd_timeout
);

    localparam int PW = $clog2(MAX_PENDING + 2);
    localparam logic [PW-1:0] PMAX  = {PW{1'b1}};
    localparam logic [PW-1:0] PLIM  = PW'(MAX_PENDING);

    logic          acc;
    logic          rsp;
    logic          matched;
    logic          run;
    logic [PW-1:0] pend;

    assign acc = accepted(rd, wq);

    generate
        if (HAS_RDV) begin : g_strobe
            assign rsp = rdv;
        end else if (FIXED_LAT == 0) begin : g_lat0
            logic unused_rdv;
            assign unused_rdv = rdv;
            assign rsp = acc;
        end else begin : g_latn
            logic                 unused_rdv;
            logic [FIXED_LAT-1:0] pipe;
            assign unused_rdv = rdv;
            always_ff @(posedge clk) begin
                if (rst) begin
                    pipe <= '0;
                end else begin
                    pipe <= (pipe << 1) | FIXED_LAT'(acc);
                end
            end
            assign rsp = pipe[FIXED_LAT-1];
        end
    endgenerate

    assign matched = rsp && ((pend != '0) || acc);
    assign orphan  = rsp && (pend == '0) && !acc;
    assign ovf     = acc && !matched && (pend >= PLIM);
    assign run     = (pend != '0) && !matched;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else if (acc && !matched) begin
            if (pend != PMAX) pend <= pend + 1'b1;
        end else if (!acc && matched) begin
            pend <= pend - 1'b1;
        end
    end

    mmwd_age_timer #(.LIMIT(RD_LIMIT)) u_rsp_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .fire (rd_timeout)
    );

    // R4
    pend_step_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend == $past(pend)) ||
                  (pend == $past(pend) + 1'b1) ||
                  (pend == $past(pend) - 1'b1)));

endmodule

// File: rtl/mmwd_write_tracker.sv
module mmwd_write_tracker
    import mmwd_pkg::*;
#(
    parameter int BURST_W  = 4,
    parameter int WR_LIMIT = 100
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,
    input  logic               wq,
    input  logic [BURST_W-1:0] burst,
    output logic               wr_timeout
);

    wburst_state_t      st;
    logic [BURST_W-1:0] left;
    logic               acc;
    logic               finishing;
    logic               run;

    assign acc       = accepted(wr, wq);
    assign finishing = (st == WB_BURST) && acc && (left == BURST_W'(1));
    assign run       = (st == WB_BURST) && !finishing;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= WB_IDLE;
            left <= '0;
        end else if (st == WB_IDLE) begin
            if (acc && (burst > BURST_W'(1))) begin
                st   <= WB_BURST;
                left <= burst - 1'b1;
            end
        end else if (acc) begin
            if (left == BURST_W'(1)) begin
                st <= WB_IDLE;
            end else begin
                left <= left - 1'b1;
            end
        end
    end

    mmwd_age_timer #(.LIMIT(WR_LIMIT)) u_burst_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .fire (wr_timeout)
    );

    // R6
    beat_dec_chk: assert property (@(posedge clk) disable iff (rst)
        ((st == WB_BURST) && acc && (left > BURST_W'(1))) |=>
            ((st == WB_BURST) && (left == $past(left) - 1'b1)));

endmodule

// File: rtl/mm_stall_watchdog.sv
module mm_stall_watchdog
    import mmwd_pkg::*;
#(
    parameter int BURST_W     = 4,
    parameter int RD_LIMIT    = 100,
    parameter int WR_LIMIT    = 100,
    parameter int STALL_LIMIT = 1024,
    parameter int MAX_PENDING = 1,
    parameter bit HAS_RDV     = 1'b1,
    parameter int FIXED_LAT   = 0,
    parameter bit REG_IN      = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_read,
    input  logic               bus_write,
    input  logic               bus_waitreq,
    input  logic               bus_rdvalid,
    input  logic [BURST_W-1:0] bus_burstcount,
    output logic [4:0]         err_pulse,
    output logic [4:0]         err_flag
);

    bus_smp_t           smp;
    logic [BURST_W-1:0] smp_burst;
    err_vec_t           hit;

    mmwd_in_stage #(.BURST_W(BURST_W), .REG_IN(REG_IN)) u_in (
        .clk       (clk),
        .rst       (rst),
        .rd        (bus_read),
        .wr        (bus_write),
        .wq        (bus_waitreq),
        .rdv       (bus_rdvalid),
        .burst     (bus_burstcount),
        .smp       (smp),
        .smp_burst (smp_burst)
    );

    mmwd_age_timer #(.LIMIT(STALL_LIMIT)) u_stall_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (smp.wq),
        .fire (hit[ERR_STALL])
    );

    mmwd_read_tracker #(
        .MAX_PENDING (MAX_PENDING),
        .HAS_RDV     (HAS_RDV),
        .FIXED_LAT   (FIXED_LAT),
        .RD_LIMIT    (RD_LIMIT)
    ) u_rd (
        .clk        (clk),
        .rst        (rst),
        .rd         (smp.rd),
        .wq         (smp.wq),
        .rdv        (smp.rdv),
        .ovf        (hit[ERR_OVF]),
        .orphan     (hit[ERR_ORPH]),
        .rd_timeout (hit[ERR_RDTO])
    );

    mmwd_write_tracker #(.BURST_W(BURST_W), .WR_LIMIT(WR_LIMIT)) u_wr (
        .clk        (clk),
        .rst        (rst),
        .wr         (smp.wr),
        .wq         (smp.wq),
        .burst      (smp_burst),
        .wr_timeout (hit[ERR_WRTO])
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            err_pulse <= '0;
            err_flag  <= '0;
        end else begin
            err_pulse <= hit;
            err_flag  <= err_flag | hit;
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_ERR; gi++) begin : g_sticky
            // R7
            sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
                err_flag[gi] |=> err_flag[gi]);
        end
    endgenerate

    // R5
    ovf_orphan_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(err_pulse[ERR_OVF] && err_pulse[ERR_ORPH]));

endmodule

// File: tb/mm_stall_watchdog_tb.sv
module mm_stall_watchdog_tb;

    localparam int BW   = 4;
    localparam int RT   = 100;
    localparam int WT   = 100;
    localparam int QT   = 1024;
    localparam int MP   = 1;
    localparam int PMAX = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic          rd = 0, wr = 0, wq = 0, rdv = 0;
    logic [BW-1:0] bc = '0;
    logic [4:0]    p0, f0, p1, f1, p2, f2;

    mm_stall_watchdog u_dut (
        .clk(clk), .rst(rst), .bus_read(rd), .bus_write(wr), .bus_waitreq(wq),
        .bus_rdvalid(rdv), .bus_burstcount(bc), .err_pulse(p0), .err_flag(f0));

    mm_stall_watchdog #(.REG_IN(1'b1)) u_dut_reg (
        .clk(clk), .rst(rst), .bus_read(rd), .bus_write(wr), .bus_waitreq(wq),
        .bus_rdvalid(rdv), .bus_burstcount(bc), .err_pulse(p1), .err_flag(f1));

    mm_stall_watchdog #(.HAS_RDV(1'b0), .FIXED_LAT(2), .MAX_PENDING(4)) u_dut_fix (
        .clk(clk), .rst(rst), .bus_read(rd), .bus_write(wr), .bus_waitreq(wq),
        .bus_rdvalid(rdv), .bus_burstcount(bc), .err_pulse(p2), .err_flag(f2));

    int nchk = 0, nfail = 0;
    bit done = 0;

    int wc, rc, pend, xc, left;
    bit inb;
    logic [4:0] ep, ef, ep_d, ef_d;

    task automatic chk(input string rq, input logic [4:0] act, input logic [4:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %b expected %b at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        wc = 0; rc = 0; pend = 0; xc = 0; left = 0; inb = 0;
        ep = '0; ef = '0; ep_d = '0; ef_d = '0;
    endtask

    // Reference model advanced with the values sampled at one clock edge
    task automatic model_step();
        logic [4:0] h;
        bit ar, aw, matched, run, fin, runw;
        int n;
        h  = '0;
        ar = rd && !wq;
        aw = wr && !wq;
        // R2 stall window
        h[0] = wq && (wc == QT - 1);
        wc   = wq ? ((wc < QT) ? wc + 1 : wc) : 0;
        // R3 R4 R5 reads
        matched = rdv && ((pend != 0) || ar);
        h[4] = rdv && (pend == 0) && !ar;
        h[3] = ar && !matched && (pend >= MP);
        run  = (pend != 0) && !matched;
        h[1] = run && (rc == RT - 1);
        rc   = run ? ((rc < RT) ? rc + 1 : rc) : 0;
        if (ar && !matched) pend = (pend < PMAX) ? pend + 1 : pend;
        else if (!ar && matched) pend = pend - 1;
        // R6 bursts
        fin  = inb && aw && (left == 1);
        runw = inb && !fin;
        h[2] = runw && (xc == WT - 1);
        xc   = runw ? ((xc < WT) ? xc + 1 : xc) : 0;
        if (inb) begin
            if (aw) begin
                if (left == 1) inb = 0;
                else left = left - 1;
            end
        end else if (aw) begin
            n = (bc == 0) ? 1 : int'(bc);
            if (n > 1) begin
                inb = 1;
                left = n - 1;
            end
        end
        ep_d = ep;
        ef_d = ef;
        ep   = h;
        ef   = ef | h;
    endtask

    task automatic step(input logic r, input logic w, input logic q,
                        input logic v, input logic [BW-1:0] b);
        @(negedge clk);
        rd = r; wr = w; wq = q; rdv = v; bc = b;
        model_step();
        @(posedge clk);
        #1;
        chk("R2 stall pulse",       {4'b0, p0[0]}, {4'b0, ep[0]});
        chk("R3 read timeout pulse", {4'b0, p0[1]}, {4'b0, ep[1]});
        chk("R6 write timeout pulse", {4'b0, p0[2]}, {4'b0, ep[2]});
        chk("R4 overflow pulse",    {4'b0, p0[3]}, {4'b0, ep[3]});
        chk("R5 orphan pulse",      {4'b0, p0[4]}, {4'b0, ep[4]});
        chk("R7 sticky flags",      f0, ef);
        chk("R8 registered pulses", p1, ep_d);
        chk("R8 registered flags",  f1, ef_d);
        chk("R10 fixed-latency stall/write", p2 & 5'b00101, ep & 5'b00101);
        chk("R10 fixed-latency read faults", f2 & 5'b10010, 5'b0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, '0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; rd = 0; wr = 0; wq = 0; rdv = 0; bc = '0;
        repeat (3) @(posedge clk);
        #1;
        // R9
        chk("R9 reset pulses", p0 | p1 | p2, 5'b0);
        chk("R9 reset flags",  f0 | f1 | f2, 5'b0);
        model_clear();
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd20240613;
        void'($urandom(seed));
        model_clear();
        do_reset();

        // R2: stall of exactly the limit and beyond, then a broken stretch
        for (int i = 0; i < QT + 5; i++) step(0, 0, 1, 0, '0);
        idle(2);
        for (int i = 0; i < QT - 1; i++) step(0, 0, 1, 0, '0);
        idle(2);

        // R3: read never answered, then late answer
        step(1, 0, 0, 0, '0);
        idle(RT + 3);
        step(0, 0, 0, 1, '0);
        // R3 boundary: answer in the last allowed cycle
        step(1, 0, 0, 0, '0);
        idle(RT - 1);
        step(0, 0, 0, 1, '0);
        idle(2);

        // R4: two reads in flight against a maximum of one
        step(1, 0, 0, 0, '0);
        step(1, 0, 0, 0, '0);
        step(0, 0, 0, 1, '0);
        step(0, 0, 0, 1, '0);
        // R5: orphan response, and a response matched in its own cycle
        step(0, 0, 0, 1, '0);
        step(1, 0, 0, 1, '0);
        idle(2);

        // R1: read held under stall is not accepted, so the response is an orphan
        for (int i = 0; i < 20; i++) step(1, 0, 1, 0, '0);
        step(0, 0, 0, 1, '0);
        idle(2);

        // R6: burst of four stalled past the window, then completed
        step(0, 1, 0, 0, 4'd4);
        idle(WT + 3);
        step(0, 1, 0, 0, '0);
        step(0, 1, 1, 0, '0);
        step(0, 1, 0, 0, '0);
        step(0, 1, 0, 0, '0);
        // R6: length zero and one are single beats
        step(0, 1, 0, 0, 4'd0);
        step(0, 1, 0, 0, 4'd1);
        idle(WT + 2);

        // R9: flags set above must clear
        do_reset();

        for (int i = 0; i < 4000; i++) begin
            logic r, w, q, v;
            logic [BW-1:0] b;
            r = ($urandom % 100) < 30;
            w = ($urandom % 100) < 25;
            q = ($urandom % 100) < 35;
            v = ($urandom % 100) < 30;
            b = BW'($urandom % 4);
            step(r, w, q, v, b);
        end
        for (int i = 0; i < 300; i++) begin
            step(($urandom % 100) < 5, 0, ($urandom % 100) < 90, 0, '0);
        end
        idle(5);

        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule